// File: doc/BRIEF.md
# Dirty Replica Backup Cache

This block is a small fully associative side store that holds a second copy of dirty data for level-two cache blocks known to contain defective cells. The error-correcting code of such a block is already used up masking the defects, so a later soft error could corrupt the only up-to-date copy. This store supplies that missing protection. Blocks without defects, and blocks that are clean, are never copied. A clean block that suffers a soft error is simply fetched again from memory.

The level-two cache reports each write with its address, data, a defect flag and a dirty flag. Only writes with both flags set are kept. A write to an address already held overwrites that entry in place. A write that misses goes into a free slot when one exists. When the store is full, the least recently written entry is chosen as the victim. Its contents are offered to main memory on a valid/ready write channel, and its slot is refilled only once memory accepts the transfer. As a result, every copy that leaves the store has been written to memory.

When the level-two cache writes a dirty block back to memory itself, it sends an eviction notice. Any matching entry is then dropped without a second memory write. When the level-two cache finds an uncorrectable error, it issues a recovery read. A hit returns the replica one cycle later. A miss on a block the cache marks dirty is flagged as unrecoverable. The controller has two states. `ST_IDLE` accepts one request per cycle. `ST_FLUSH` presents the victim to memory. The transition `IDLE->FLUSH` is taken on a kept write that misses while the store is full. The transition `FLUSH->IDLE` is taken on the memory handshake, which also installs the pending write.

Top module: `dirty_replica_cache`

## Requirements
- R1: After reset no entry is held, `req_ready` is 1, and both `mem_valid` and `rec_done` are 0.
- R2: A write accepted with `wr_defect`=1 and `wr_dirty`=1 to an address not held is stored in a free slot without any memory transfer. A later recovery read of that address returns `rec_hit`=1 and the written data.
- R3: A write with `wr_defect`=0 or `wr_dirty`=0 is ignored. It starts no memory transfer, and a recovery read of its address misses.
- R4: A kept write to an address already held replaces that entry's data in place, with no memory transfer.
- R5: A kept write that misses while every slot is valid raises `mem_valid` with the address and data of the entry least recently written or updated. Recovery reads do not count as use. `req_ready` stays 0 until memory accepts. After acceptance the new data is held and the victim address misses.
- R6: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` stay unchanged on the next cycle.
- R7: An eviction notice drops a matching entry without any memory transfer. A notice for an address not held changes nothing.
- R8: A recovery read that misses returns `rec_hit`=0 and `rec_fatal` equal to `rec_dirty`. A hit never sets `rec_fatal`.
- R9: `rec_done` pulses exactly in the cycle after a recovery read is accepted, and at no other time.
- R10: A slot freed by an eviction notice is reused by the next kept write that misses, with no memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Level-two write event |
| wr_addr | input | ADDR_W | Block address of the write |
| wr_data | input | DATA_W | Written block data |
| wr_defect | input | 1 | Block contains a defective cell |
| wr_dirty | input | 1 | Block is dirty after the write |
| evict_valid | input | 1 | Level-two cache wrote this block to memory itself |
| evict_addr | input | ADDR_W | Address of the evicted block |
| rec_valid | input | 1 | Recovery read request |
| rec_addr | input | ADDR_W | Address to recover |
| rec_dirty | input | 1 | Level-two cache marks that block dirty |
| req_ready | output | 1 | Requests are accepted this cycle |
| rec_done | output | 1 | Recovery result valid |
| rec_hit | output | 1 | Replica found |
| rec_fatal | output | 1 | Dirty block without replica |
| rec_data | output | DATA_W | Replica data (zero on miss) |
| mem_valid | output | 1 | Write-back to memory pending |
| mem_ready | input | 1 | Memory accepts the write-back |
| mem_addr | output | ADDR_W | Write-back address |
| mem_data | output | DATA_W | Write-back data |

## Verification
The checker assumes that the write, eviction and recovery inputs are valid in at most one cycle-aligned request at a time. It also assumes that a request is only taken as accepted in a cycle where `req_ready` is 1. The bench drives exactly one request per handshake and waits on `req_ready` before releasing it. The checker also assumes that memory never withdraws `mem_ready` in a way that matters before `mem_valid`. The bench keeps `mem_ready` low except in single deliberate acceptance cycles, so every hold window and every handshake is placed on purpose.

// File: rtl/drc_pkg.sv
package drc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } drc_state_e;
endpackage

// File: rtl/drc_match.sv
module drc_match #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid_vec,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              lk_addr,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           has_free,
    output logic [IDX_W-1:0]               free_idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_vec[g] && (tags[g] == lk_addr);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i])         hit_idx  = IDX_W'(i);
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign hit      = |eq;
    assign has_free = ~&valid_vec;
endmodule

// File: rtl/drc_lru.sv
module drc_lru #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               touch_en,
    input  logic               touch_fresh,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               drop_en,
    input  logic [IDX_W-1:0]   drop_idx,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              ref_age;
    logic [IDX_W-1:0]              drop_age;

    assign ref_age  = age_q[touch_idx];
    assign drop_age = age_q[drop_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (valid_vec[i] && (touch_fresh || age_q[i] < ref_age))
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end else if (drop_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (valid_vec[i] && age_q[i] > drop_age)
                    age_q[i] <= age_q[i] - 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_vec[i] && age_q[i] == OLDEST) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dirty_replica_cache.sv
module dirty_replica_cache
    import drc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_defect,
    input  logic              wr_dirty,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic              rec_dirty,
    output logic              req_ready,
    output logic              rec_done,
    output logic              rec_hit,
    output logic              rec_fatal,
    output logic [DATA_W-1:0] rec_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    localparam int IDX_W = $clog2(ENTRIES);

    drc_state_e state_q, state_d;

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;
    logic [ADDR_W-1:0]              pend_addr_q;
    logic [DATA_W-1:0]              pend_data_q;
    logic [IDX_W-1:0]               vic_q;

    logic [ADDR_W-1:0] lk_addr;
    logic              hit, has_free;
    logic [IDX_W-1:0]  hit_idx, free_idx, victim_idx;
    logic              in_idle, wr_take, ev_take, rc_take;

    logic              ins_en, ins_fresh, drop_en;
    logic [IDX_W-1:0]  ins_idx;
    logic [ADDR_W-1:0] ins_addr;
    logic [DATA_W-1:0] ins_data;

    assign in_idle = (state_q == ST_IDLE);
    assign wr_take = in_idle && wr_valid && wr_defect && wr_dirty;
    assign ev_take = in_idle && evict_valid;
    assign rc_take = in_idle && rec_valid;
    assign lk_addr = rec_valid ? rec_addr : (evict_valid ? evict_addr : wr_addr);

    drc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .valid_vec (valid_q),
        .tags      (tag_q),
        .lk_addr   (lk_addr),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .has_free  (has_free),
        .free_idx  (free_idx)
    );

    drc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_vec   (valid_q),
        .touch_en    (ins_en),
        .touch_fresh (ins_fresh),
        .touch_idx   (ins_idx),
        .drop_en     (drop_en),
        .drop_idx    (hit_idx),
        .victim_idx  (victim_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_take && !hit && !has_free) state_d = ST_FLUSH;
            ST_FLUSH: if (mem_ready)                    state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and slot control per state
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        ins_en    = 1'b0;
        ins_fresh = 1'b0;
        ins_idx   = hit_idx;
        ins_addr  = wr_addr;
        ins_data  = wr_data;
        drop_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (wr_take && hit) begin
                    ins_en = 1'b1;
                end else if (wr_take && has_free) begin
                    ins_en    = 1'b1;
                    ins_fresh = 1'b1;
                    ins_idx   = free_idx;
                end
                drop_en = ev_take && hit;
            end
            ST_FLUSH: begin
                mem_valid = 1'b1;
                ins_idx   = vic_q;
                ins_addr  = pend_addr_q;
                ins_data  = pend_data_q;
                ins_en    = mem_ready;
            end
            default: ;
        endcase
    end

    assign mem_addr = tag_q[vic_q];
    assign mem_data = data_q[vic_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q     <= '0;
            vic_q       <= '0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            rec_done    <= 1'b0;
            rec_hit     <= 1'b0;
            rec_fatal   <= 1'b0;
            rec_data    <= '0;
        end else begin
            if (ins_en)  valid_q[ins_idx] <= 1'b1;
            if (drop_en) valid_q[hit_idx] <= 1'b0;
            if (in_idle && state_d == ST_FLUSH) begin
                vic_q       <= victim_idx;
                pend_addr_q <= wr_addr;
                pend_data_q <= wr_data;
            end
            rec_done  <= rc_take;
            rec_hit   <= rc_take && hit;
            rec_fatal <= rc_take && !hit && rec_dirty;
            rec_data  <= (rc_take && hit) ? data_q[hit_idx] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[ins_idx]  <= ins_addr;
            data_q[ins_idx] <= ins_data;
        end
    end
endmodule

// File: rtl/dirty_replica_cache_chk.sv
module dirty_replica_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_defect,
    input logic              wr_dirty,
    input logic              evict_valid,
    input logic              rec_valid,
    input logic              rec_dirty,
    input logic              req_ready,
    input logic              rec_done,
    input logic              rec_hit,
    input logic              rec_fatal,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R6

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(wr_valid && wr_defect && wr_dirty && req_ready)); // R5

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && req_ready && !(wr_defect && wr_dirty) |=> !mem_valid); // R3

    AST_EVICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid && req_ready |=> !mem_valid); // R7

    AST_REC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> $past(rec_valid && req_ready)); // R9

    AST_REC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> !(rec_hit && rec_fatal)); // R8

    AST_FATAL_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done && rec_fatal |-> $past(rec_dirty)); // R8
endmodule

bind dirty_replica_cache dirty_replica_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_defect   (wr_defect),
    .wr_dirty    (wr_dirty),
    .evict_valid (evict_valid),
    .rec_valid   (rec_valid),
    .rec_dirty   (rec_dirty),
    .req_ready   (req_ready),
    .rec_done    (rec_done),
    .rec_hit     (rec_hit),
    .rec_fatal   (rec_fatal),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data)
);

// File: tb/dirty_replica_cache_tb.sv
module dirty_replica_cache_tb;
    localparam int ENTRIES = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_defect = 0, wr_dirty = 0;
    logic [AW-1:0] wr_addr = '0, evict_addr = '0, rec_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic evict_valid = 0, rec_valid = 0, rec_dirty = 0, mem_ready = 0;
    logic req_ready, rec_done, rec_hit, rec_fatal, mem_valid;
    logic [DW-1:0] rec_data, mem_data;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dirty_replica_cache #(.ENTRIES(ENTRIES), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_defect(wr_defect), .wr_dirty(wr_dirty),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_dirty(rec_dirty),
        .req_ready(req_ready), .rec_done(rec_done), .rec_hit(rec_hit),
        .rec_fatal(rec_fatal), .rec_data(rec_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [DW-1:0] dval(input int a, input int gen);
        return DW'(a * 257) ^ DW'(gen * 16'h1111) ^ 16'h5A00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit def, input bit dty);
        while (!req_ready) @(negedge clk);
        wr_valid = 1; wr_addr = AW'(a); wr_data = d; wr_defect = def; wr_dirty = dty;
        @(posedge clk); @(negedge clk);
        wr_valid = 0; wr_defect = 0; wr_dirty = 0;
    endtask

    task automatic do_evict(input int a);
        evict_valid = 1; evict_addr = AW'(a);
        @(posedge clk); @(negedge clk);
        evict_valid = 0;
    endtask

    task automatic do_rec(input int a, input bit dty, input string req,
                          input bit exp_hit, input logic [DW-1:0] exp_data);
        rec_valid = 1; rec_addr = AW'(a); rec_dirty = dty;
        @(posedge clk); @(negedge clk);
        rec_valid = 0; rec_dirty = 0;
        chk(rec_done == 1'b1, {req, " rec_done"}, 32'(rec_done), 1);
        chk(rec_hit == exp_hit, {req, " rec_hit"}, 32'(rec_hit), 32'(exp_hit));
        chk(rec_fatal == (!exp_hit && dty), {req, " rec_fatal"}, 32'(rec_fatal), 32'(!exp_hit && dty));
        if (exp_hit) chk(rec_data == exp_data, {req, " rec_data"}, 32'(rec_data), 32'(exp_data));
        @(posedge clk); @(negedge clk);
        chk(rec_done == 1'b0, "R9 single pulse", 32'(rec_done), 0);
    endtask

    task automatic accept_wb;
        mem_ready = 1;
        @(posedge clk); @(negedge clk);
        mem_ready = 0;
        chk(mem_valid == 1'b0, "R5 handshake clears", 32'(mem_valid), 0);
        chk(req_ready == 1'b1, "R5 ready after accept", 32'(req_ready), 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
        chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
        chk(rec_done == 1'b0, "R1 rec_done", 32'(rec_done), 0);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < ENTRIES; a++) do_rec(a, 1'b1, "R1 empty", 1'b0, '0);

        // R2 fill every slot
        for (int a = 0; a < ENTRIES; a++) begin
            do_write(a, dval(a, 0), 1'b1, 1'b1);
            chk(mem_valid == 1'b0, "R2 no transfer on fill", 32'(mem_valid), 0);
        end
        for (int a = 0; a < ENTRIES; a++) do_rec(a, 1'b1, "R2 hit", 1'b1, dval(a, 0));

        // R3 every non-kept flag combination, also against a full store
        for (int f = 0; f < 3; f++) begin
            do_write(8'h40 + f, dval(8'h40, f), f[0], f[1]);
            chk(mem_valid == 1'b0, "R3 no transfer", 32'(mem_valid), 0);
            do_rec(8'h40 + f, 1'b0, "R3 ignored", 1'b0, '0);
        end
        for (int f = 0; f < 3; f++) begin
            do_write(2, dval(2, 7), f[0], f[1]);
            do_rec(2, 1'b1, "R3 held data kept", 1'b1, dval(2, 0));
        end

        // R4 in-place update of address 1
        do_write(1, dval(1, 1), 1'b1, 1'b1);
        chk(mem_valid == 1'b0, "R4 no transfer", 32'(mem_valid), 0);
        do_rec(1, 1'b1, "R4 updated", 1'b1, dval(1, 1));

        // R5 full miss: least recent is address 0; R6 hold while not ready
        do_write(8'h50, dval(8'h50, 0), 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            chk(mem_valid == 1'b1, "R6 valid held", 32'(mem_valid), 1);
            chk(mem_addr == AW'(0), "R5 victim addr", 32'(mem_addr), 0);
            chk(mem_data == dval(0, 0), "R6 data held", 32'(mem_data), 32'(dval(0, 0)));
            chk(req_ready == 1'b0, "R5 stalled", 32'(req_ready), 0);
            @(negedge clk);
        end
        accept_wb();
        do_rec(0, 1'b1, "R5 victim gone R8 fatal", 1'b0, '0);
        do_rec(8'h50, 1'b1, "R5 new held", 1'b1, dval(8'h50, 0));

        // R5 next victim is address 2
        do_write(8'h51, dval(8'h51, 0), 1'b1, 1'b1);
        chk(mem_valid == 1'b1, "R5 second flush", 32'(mem_valid), 1);
        chk(mem_addr == AW'(2), "R5 second victim", 32'(mem_addr), 2);
        chk(mem_data == dval(2, 0), "R5 second data", 32'(mem_data), 32'(dval(2, 0)));
        accept_wb();

        // R7 eviction notices
        do_evict(3);
        chk(mem_valid == 1'b0, "R7 no transfer", 32'(mem_valid), 0);
        do_rec(3, 1'b0, "R7 dropped R8 clean", 1'b0, '0);
        do_evict(8'h77);
        chk(mem_valid == 1'b0, "R7 no transfer miss", 32'(mem_valid), 0);
        do_rec(1, 1'b1, "R7 others kept", 1'b1, dval(1, 1));
        do_rec(8'h51, 1'b1, "R7 others kept", 1'b1, dval(8'h51, 0));

        // R10 freed slot reused, then full again: victim is address 1
        do_write(8'h52, dval(8'h52, 0), 1'b1, 1'b1);
        chk(mem_valid == 1'b0, "R10 reuse no transfer", 32'(mem_valid), 0);
        do_rec(8'h52, 1'b1, "R10 held", 1'b1, dval(8'h52, 0));
        do_write(8'h53, dval(8'h53, 0), 1'b1, 1'b1);
        chk(mem_valid == 1'b1, "R5 third flush", 32'(mem_valid), 1);
        chk(mem_addr == AW'(1), "R5 third victim", 32'(mem_addr), 1);
        chk(mem_data == dval(1, 1), "R5 third data", 32'(mem_data), 32'(dval(1, 1)));
        accept_wb();
        do_rec(8'h53, 1'b1, "R5 third held", 1'b1, dval(8'h53, 0));

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule